// File: doc/BRIEF.md
# Halfword Instruction Stream Aligner

This block stands between a 32-bit instruction memory port and the instruction decoder of a core that mixes 16-bit and 32-bit instructions. It issues word-aligned fetch requests, keeps the returned data as a small queue of halfwords, and works out where each instruction ends by looking only at the two lowest bits of the halfword at the queue head. Each cycle it can hand the decoder one complete instruction, with a flag giving its length and the address it was fetched from.

A 32-bit instruction may begin on any halfword boundary, so its two halves can come from two different fetch words. The aligner joins them. A redirect can point at either halfword of a word. It drops all queued halfwords and every fetch response still in flight, and it restarts fetching at the word that contains the target. Fetch requests stop while the queue, together with the responses already owed to it, would fill the buffer. The fetch unit can therefore idle while the decoder stalls.

Top module: `fetch_aligner`

## Requirements
- R1: A head halfword whose bits [1:0] are 2'b11 begins a 32-bit instruction: out_is32=1 and out_instr={second halfword, first halfword}. Any other value of bits [1:0] (00, 01, 10) gives a 16-bit instruction: out_is32=0 and out_instr={16'h0000, halfword}.
- R2: A head halfword whose bits [4:0] are 5'b11111 is never issued: out_valid stays 0 and out_illegal stays 1 until the next redirect. After that redirect, normal issue resumes at the new target.
- R3: A 32-bit instruction that starts at byte offset 2 of a fetch word is put out whole, with its upper half taken from the following fetch word.
- R4: After a redirect to an address with bit 1 set, the lower halfword of the first returned word is discarded. The first instruction put out has out_pc equal to the target.
- R5: Each accepted instruction moves out_pc on by 2 for a 16-bit instruction and by 4 for a 32-bit instruction.
- R6: A redirect empties the buffer and discards every fetch response requested before it. The next instruction put out is the one at the target address, and the cycle after the redirect shows out_pc equal to the target.
- R7: While out_valid=1 and out_ready=0, out_instr, out_is32 and out_pc hold their values. After any stall, the stream continues with no halfword lost or repeated.
- R8: A request is raised only when the queued halfwords plus two for each outstanding response plus two more fit within BUF_HW. A full buffer therefore keeps req_valid low, and the request is also held off in a redirect cycle.
- R9: req_addr always has bits [1:0]=2'b00. Accepted requests run at +4 steps from the word holding the last redirect target, or from RESET_PC after reset.
- R10: During and just after reset, out_valid=0, out_illegal=0 and out_pc=RESET_PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | output | 1 | Fetch request valid |
| req_ready | input | 1 | Memory accepts the request |
| req_addr | output | AW | Word-aligned fetch address |
| rsp_valid | input | 1 | Fetch response valid; responses return in request order |
| rsp_data | input | 32 | Fetched word; the lower halfword is at the lower address |
| redir_valid | input | 1 | Redirect strobe |
| redir_pc | input | AW | Halfword-aligned redirect target |
| out_valid | output | 1 | Instruction available to the decoder |
| out_ready | input | 1 | Decoder accepts the instruction |
| out_instr | output | 32 | Instruction bits, zero-extended when 16-bit |
| out_is32 | output | 1 | 1 for a 32-bit instruction |
| out_illegal | output | 1 | Head halfword is of the reserved longer format |
| out_pc | output | AW | Address of the instruction put out |

## Verification
The case that needs care is a redirect arriving in the same cycle as a fetch response, with more responses still owed from before the redirect. The memory model in the bench answers two cycles after each accepted request, so a redirect issued in the middle of a running stream always finds responses in flight and usually one on the bus. The outcome is judged at the decoder port. The first instruction after the redirect must carry the target address and the halfword stored there. Old data from the previous stream would show up as a different, address-unique value. A second overlap, a stall held against a full buffer, is judged by req_valid going low and by the stream then resuming in order.

// File: rtl/fa_pkg.sv
package fa_pkg;
   localparam int HALF_BITS = 16;
   localparam int WORD_BITS = 32;

   typedef logic [HALF_BITS-1:0] half_t;

   function automatic logic half_is_long(half_t h);
      return h[1:0] == 2'b11;
   endfunction

   function automatic logic half_is_reserved(half_t h);
      return h[4:0] == 5'b11111;
   endfunction
endpackage

// File: rtl/fa_hwbuf.sv
module fa_hwbuf
   import fa_pkg::*;
#(
   parameter int DEPTH = 4,
   localparam int PW = $clog2(DEPTH),
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic [1:0]    push_n,
   input  half_t         push_d0,
   input  half_t         push_d1,
   input  logic [1:0]    pop_n,
   output half_t         head0,
   output half_t         head1,
   output logic [CW-1:0] fill
);
   logic [DEPTH-1:0][HALF_BITS-1:0] slot;
   logic [DEPTH-1:0][HALF_BITS-1:0] wdat;
   logic [DEPTH-1:0]                wen;
   logic [PW-1:0] rd_ptr, wr_ptr, rd_nxt1, wr_nxt1;

   assign rd_nxt1 = rd_ptr + 1'b1;
   assign wr_nxt1 = wr_ptr + 1'b1;

   for (genvar e = 0; e < DEPTH; e++) begin : g_slot
      logic hit0, hit1;
      assign hit0    = (push_n != 2'd0) && (wr_ptr == PW'(e));
      assign hit1    = (push_n == 2'd2) && (wr_nxt1 == PW'(e));
      assign wen[e]  = !flush && (hit0 || hit1);
      assign wdat[e] = hit0 ? push_d0 : push_d1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot <= '0;
      end else begin
         for (int e = 0; e < DEPTH; e++) begin
            if (wen[e]) slot[e] <= wdat[e];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         fill   <= '0;
      end else if (flush) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         fill   <= '0;
      end else begin
         rd_ptr <= rd_ptr + PW'(pop_n);
         wr_ptr <= wr_ptr + PW'(push_n);
         fill   <= fill + CW'(push_n) - CW'(pop_n);
      end
   end

   assign head0 = slot[rd_ptr];
   assign head1 = slot[rd_nxt1];
endmodule

// File: rtl/fa_boundary.sv
module fa_boundary
   import fa_pkg::*;
#(
   parameter int CW = 3
) (
   input  half_t                 head0,
   input  half_t                 head1,
   input  logic [CW-1:0]         fill,
   output logic                  inst_valid,
   output logic                  inst_long,
   output logic                  inst_bad,
   output logic [WORD_BITS-1:0]  inst_bits
);
   logic have_one, have_two;

   assign have_one   = fill != '0;
   assign have_two   = fill >= CW'(2);
   assign inst_long  = half_is_long(head0);
   assign inst_bad   = have_one && half_is_reserved(head0);
   assign inst_valid = have_one && !half_is_reserved(head0) && (!inst_long || have_two);
   assign inst_bits  = inst_long ? {head1, head0} : {{HALF_BITS{1'b0}}, head0};
endmodule

// File: rtl/fa_fetch_ctrl.sv
module fa_fetch_ctrl #(
   parameter int          AW       = 32,
   parameter int          DEPTH    = 4,
   parameter logic [AW-1:0] RESET_PC = '0,
   localparam int CW  = $clog2(DEPTH + 1),
   localparam int OCW = $clog2(DEPTH / 2 + 1),
   localparam int SW  = CW + OCW + 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          redir_valid,
   input  logic [AW-3:0] tgt_word,
   input  logic          tgt_odd,
   input  logic [CW-1:0] fill,
   output logic          req_valid,
   input  logic          req_ready,
   output logic [AW-1:0] req_addr,
   input  logic          rsp_valid,
   output logic          rsp_keep,
   output logic          rsp_skip_lo
);
   logic [AW-3:0]  fa_q;
   logic [OCW-1:0] outst_q, drop_q;
   logic           skip_q;
   logic [SW-1:0]  need;
   logic           req_fire;

   assign need        = SW'(fill) + (SW'(outst_q) << 1) + SW'(2);
   assign req_valid   = !redir_valid && (need <= SW'(DEPTH));
   assign req_fire    = req_valid && req_ready;
   assign req_addr    = {fa_q, 2'b00};
   assign rsp_keep    = rsp_valid && (drop_q == '0) && !redir_valid;
   assign rsp_skip_lo = skip_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fa_q    <= RESET_PC[AW-1:2];
         skip_q  <= RESET_PC[1];
         outst_q <= '0;
         drop_q  <= '0;
      end else begin
         outst_q <= outst_q + OCW'(req_fire) - OCW'(rsp_valid);
         if (redir_valid) begin
            fa_q   <= tgt_word;
            skip_q <= tgt_odd;
            drop_q <= outst_q - OCW'(rsp_valid);
         end else begin
            if (req_fire) fa_q <= fa_q + 1'b1;
            if (rsp_valid && drop_q != '0) drop_q <= drop_q - 1'b1;
            if (rsp_keep) skip_q <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/fetch_aligner.sv
module fetch_aligner
   import fa_pkg::*;
#(
   parameter int            AW       = 32,
   parameter int            BUF_HW   = 4,
   parameter logic [AW-1:0] RESET_PC = '0,
   localparam int CW = $clog2(BUF_HW + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   output logic          req_valid,
   input  logic          req_ready,
   output logic [AW-1:0] req_addr,
   input  logic          rsp_valid,
   input  logic [31:0]   rsp_data,
   input  logic          redir_valid,
   input  logic [AW-1:0] redir_pc,
   output logic          out_valid,
   input  logic          out_ready,
   output logic [31:0]   out_instr,
   output logic          out_is32,
   output logic          out_illegal,
   output logic [AW-1:0] out_pc
);
   if (BUF_HW < 4 || (BUF_HW & (BUF_HW - 1)) != 0) begin : g_bad_depth
      $error("fetch_aligner: BUF_HW must be a power of two of at least 4");
   end
   if (AW < 3) begin : g_bad_aw
      $error("fetch_aligner: AW must be at least 3");
   end
   if (RESET_PC[0] != 1'b0) begin : g_bad_reset_pc
      $error("fetch_aligner: RESET_PC must be halfword aligned");
   end

   logic [CW-1:0] buf_fill;
   half_t         head0, head1;
   logic          rsp_keep, rsp_skip_lo;
   logic          inst_valid, inst_long, inst_bad;
   logic [31:0]   inst_bits;
   logic [1:0]    push_n, pop_n;
   logic          fire;
   logic [AW-1:0] pc_q;

   fa_fetch_ctrl #(.AW(AW), .DEPTH(BUF_HW), .RESET_PC(RESET_PC)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .redir_valid(redir_valid),
      .tgt_word(redir_pc[AW-1:2]), .tgt_odd(redir_pc[1]), .fill(buf_fill),
      .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
      .rsp_valid(rsp_valid), .rsp_keep(rsp_keep), .rsp_skip_lo(rsp_skip_lo)
   );

   assign push_n = rsp_keep ? (rsp_skip_lo ? 2'd1 : 2'd2) : 2'd0;
   assign fire   = inst_valid && out_ready;
   assign pop_n  = fire ? (inst_long ? 2'd2 : 2'd1) : 2'd0;

   fa_hwbuf #(.DEPTH(BUF_HW)) u_buf (
      .clk(clk), .rst_n(rst_n), .flush(redir_valid), .push_n(push_n),
      .push_d0(rsp_skip_lo ? rsp_data[31:16] : rsp_data[15:0]),
      .push_d1(rsp_data[31:16]), .pop_n(pop_n),
      .head0(head0), .head1(head1), .fill(buf_fill)
   );

   fa_boundary #(.CW(CW)) u_bound (
      .head0(head0), .head1(head1), .fill(buf_fill),
      .inst_valid(inst_valid), .inst_long(inst_long),
      .inst_bad(inst_bad), .inst_bits(inst_bits)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           pc_q <= RESET_PC;
      else if (redir_valid) pc_q <= redir_pc;
      else if (fire)        pc_q <= pc_q + (inst_long ? AW'(4) : AW'(2));
   end

   assign out_valid   = inst_valid;
   assign out_instr   = inst_bits;
   assign out_is32    = inst_long;
   assign out_illegal = inst_bad;
   assign out_pc      = pc_q;
endmodule

// File: rtl/fetch_aligner_chk.sv
module fetch_aligner_chk #(
   parameter int AW    = 32,
   parameter int DEPTH = 4,
   localparam int CW = $clog2(DEPTH + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          req_valid,
   input logic [AW-1:0] req_addr,
   input logic          redir_valid,
   input logic [AW-1:0] redir_pc,
   input logic          out_valid,
   input logic          out_ready,
   input logic [31:0]   out_instr,
   input logic          out_is32,
   input logic          out_illegal,
   input logic [AW-1:0] out_pc,
   input logic [CW-1:0] fill
);
   p_len_flag_r1: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_is32 == (out_instr[1:0] == 2'b11)));

   p_short_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_is32) |-> (out_instr[31:16] == 16'h0000));

   p_bad_not_issued_r2: assert property (@(posedge clk) disable iff (!rst_n)
      out_illegal |-> !out_valid);

   p_pc_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready && !redir_valid) |=>
         (out_pc == $past(out_pc) + ($past(out_is32) ? AW'(4) : AW'(2))));

   p_redir_pc_r6: assert property (@(posedge clk) disable iff (!rst_n)
      redir_valid |=> (out_pc == $past(redir_pc)));

   p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready && !redir_valid) |=>
         (out_valid && $stable(out_pc) && $stable(out_instr) && $stable(out_is32)));

   p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
      fill <= CW'(DEPTH));

   p_full_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (fill == CW'(DEPTH) || redir_valid) |-> !req_valid);

   p_req_aligned_r9: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> (req_addr[1:0] == 2'b00));
endmodule

bind fetch_aligner fetch_aligner_chk #(.AW(AW), .DEPTH(BUF_HW)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
   .redir_valid(redir_valid), .redir_pc(redir_pc), .out_valid(out_valid),
   .out_ready(out_ready), .out_instr(out_instr), .out_is32(out_is32),
   .out_illegal(out_illegal), .out_pc(out_pc), .fill(buf_fill)
);

// File: tb/fetch_aligner_test.sv
module fetch_aligner_test;
   localparam int AW = 32;
   localparam int NPROG = 12;
   // {is32, instruction}; laid out back to back from address 0
   localparam logic [32:0] PROG [NPROG] = '{
      {1'b0, 32'h0000_1001}, {1'b1, 32'h1234_5673}, {1'b0, 32'h0000_2002},
      {1'b1, 32'hABCD_0013}, {1'b0, 32'h0000_3000}, {1'b0, 32'h0000_4001},
      {1'b1, 32'hCAFE_0083}, {1'b0, 32'h0000_5002}, {1'b1, 32'h0F0F_1E73},
      {1'b1, 32'h1111_0033}, {1'b0, 32'h0000_6000}, {1'b0, 32'h0000_7001}
   };

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic          rst_n, req_valid, req_ready, rsp_valid, redir_valid;
   logic          out_valid, out_ready, out_is32, out_illegal;
   logic [AW-1:0] req_addr, redir_pc, out_pc;
   logic [31:0]   rsp_data, out_instr;

   fetch_aligner #(.AW(AW), .BUF_HW(4), .RESET_PC(32'h0)) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
      .redir_valid(redir_valid), .redir_pc(redir_pc), .out_valid(out_valid),
      .out_ready(out_ready), .out_instr(out_instr), .out_is32(out_is32),
      .out_illegal(out_illegal), .out_pc(out_pc)
   );

   logic [15:0] mem [256];
   int n_chk = 0, n_bad = 0;
   logic [15:0] lfsr = 16'hACE1;

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] word_at(logic [31:0] a);
      logic [7:0] ix;
      ix = a[8:1];
      return {mem[8'(ix + 8'd1)], mem[ix]};
   endfunction

   function automatic logic [32:0] ref_at(logic [31:0] pc);
      logic [7:0] ix;
      ix = pc[8:1];
      if (mem[ix][1:0] == 2'b11) return {1'b1, mem[8'(ix + 8'd1)], mem[ix]};
      return {1'b0, 16'h0000, mem[ix]};
   endfunction

   // memory answering two cycles after each accepted request
   logic p1_v;
   logic [31:0] p1_a;
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         p1_v <= 1'b0; rsp_valid <= 1'b0; p1_a <= '0; rsp_data <= '0;
      end else begin
         p1_v      <= req_valid && req_ready;
         p1_a      <= req_addr;
         rsp_valid <= p1_v;
         rsp_data  <= word_at(p1_a);
      end
   end

   // R9: request address sequence
   logic [31:0] next_fa = 32'h0;
   always @(negedge clk) begin
      #1;
      if (!rst_n) next_fa = 32'h0;
      else if (redir_valid) next_fa = {redir_pc[31:2], 2'b00};
      else if (req_valid && req_ready) begin
         chk(req_addr == next_fa && req_addr[1:0] == 2'b00, "R9 req_addr", req_addr, next_fa);
         next_fa = next_fa + 32'd4;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   task automatic next_out(input bit rnd, output logic [31:0] pc, output logic [31:0] ins, output logic l32);
      bit held = 0, got = 0, rdy;
      logic [31:0] hpc = '0, hins = '0;
      int guard = 0;
      pc = 'x; ins = 'x; l32 = 1'bx;
      while (!got) begin
         @(negedge clk);
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         rdy = rnd ? (lfsr[0] | lfsr[3]) : 1'b1;
         out_ready = rdy;
         req_ready = rnd ? (lfsr[5] | lfsr[2]) : 1'b1;
         if (held && out_valid)
            chk(out_pc == hpc && out_instr == hins, "R7 stall hold", {out_pc, out_instr}, {hpc, hins});
         held = 0;
         if (out_valid && rdy) begin
            pc = out_pc; ins = out_instr; l32 = out_is32; got = 1;
         end else if (out_valid) begin
            held = 1; hpc = out_pc; hins = out_instr;
         end
         guard++;
         if (guard > 400 && !got) begin
            chk(1'b0, "R7 output timeout", 0, 1);
            got = 1;
         end
      end
      @(posedge clk);
      #1 out_ready = 1'b0; req_ready = 1'b1;
   endtask

   task automatic do_redir(input logic [31:0] t);
      @(negedge clk);
      out_ready = 1'b0; redir_valid = 1'b1; redir_pc = t;
      @(posedge clk);
      #1 redir_valid = 1'b0;
   endtask

   task automatic walk_table(input bit rnd);
      logic [31:0] epc = 32'h0, pc, ins;
      logic l;
      for (int i = 0; i < NPROG; i++) begin
         next_out(rnd, pc, ins, l);
         chk(pc == epc, "R5 pc", pc, epc);
         chk(l == PROG[i][32] && ins == PROG[i][31:0],
             (PROG[i][32] && epc[1]) ? "R3 straddle" : "R1 length/bits",
             {l, ins}, PROG[i]);
         epc = epc + (PROG[i][32] ? 32'd4 : 32'd2);
      end
   endtask

   initial begin
      logic [31:0] pc, ins;
      logic l;
      logic [32:0] e;
      int hi = 0, fired = 0;
      for (int i = 0; i < 256; i++) mem[i] = {8'(i), 8'h01};
      for (int i = 0; i < NPROG; i++) begin
         mem[hi] = PROG[i][15:0];
         if (PROG[i][32]) begin mem[hi + 1] = PROG[i][31:16]; hi += 2; end
         else hi += 1;
      end
      mem[8'h80] = 16'h001F;

      rst_n = 1'b0; out_ready = 1'b0; req_ready = 1'b1; redir_valid = 1'b0; redir_pc = '0;
      repeat (3) begin
         @(negedge clk);
         chk(!out_valid && !out_illegal, "R10 reset outputs", {out_valid, out_illegal}, 0);
      end
      rst_n = 1'b1;
      @(negedge clk);
      chk(out_pc == 32'h0, "R10 reset pc", out_pc, 0);

      // table at full rate, then filler beyond it
      walk_table(1'b0);
      next_out(1'b0, pc, ins, l);
      e = ref_at(32'd34);
      chk(pc == 32'd34 && {l, ins} == e, "R1 filler", {pc, l, ins}, {32'd34, e});

      // table again with random ready on both sides
      do_redir(32'h0);
      walk_table(1'b1);

      // odd-halfword target holding a straddling 32-bit instruction
      do_redir(32'h2);
      next_out(1'b0, pc, ins, l);
      chk(pc == 32'h2, "R4 target pc", pc, 32'h2);
      chk(l && ins == 32'h1234_5673, "R3 joined at target", {l, ins}, {1'b1, 32'h1234_5673});
      next_out(1'b0, pc, ins, l);
      chk(pc == 32'h6 && ins == 32'h2002, "R5 after 32-bit", {pc, ins}, {32'h6, 32'h2002});

      // long stall: fetch must idle, head held, then no loss
      do_redir(32'h0);
      repeat (30) @(negedge clk);
      chk(!req_valid, "R8 idle when full", req_valid, 0);
      chk(out_valid && out_pc == 32'h0 && out_instr == 32'h1001, "R7 held head",
          {out_valid, out_pc, out_instr}, {1'b1, 32'h0, 32'h1001});
      walk_table(1'b0);

      // redirect with responses in flight
      do_redir(32'h0);
      repeat (3) next_out(1'b0, pc, ins, l);
      do_redir(32'h40);
      for (int k = 0; k < 3; k++) begin
         next_out(1'b0, pc, ins, l);
         e = ref_at(32'h40 + 32'(2 * k));
         chk(pc == 32'h40 + 32'(2 * k) && {l, ins} == e, "R6 flush stale",
             {pc, l, ins}, {32'h40 + 32'(2 * k), e});
      end
      do_redir(32'h46);
      next_out(1'b0, pc, ins, l);
      chk(pc == 32'h46 && ins == 32'h0000_2301, "R4 low half dropped", {pc, ins}, {32'h46, 32'h2301});

      // reserved longer format
      do_redir(32'h100);
      out_ready = 1'b1;
      repeat (12) begin
         @(negedge clk);
         if (out_valid) fired++;
      end
      chk(fired == 0, "R2 never issued", fired, 0);
      chk(out_illegal && !out_valid, "R2 flag", {out_illegal, out_valid}, 2'b10);
      do_redir(32'h102);
      next_out(1'b0, pc, ins, l);
      chk(pc == 32'h102 && ins == 32'h0000_8101 && !out_illegal, "R2 recovery",
          {pc, ins}, {32'h102, 32'h8101});

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule